// File: doc/BRIEF.md
# Adjustable Nanosecond Time Counter

This block keeps a free-running nanosecond time base for precision time protocol timestamping. Each reference clock cycle it adds a programmable nominal increment to a 31-bit count. To trim the frequency without changing the nominal value, it replaces the nominal increment with a second, corrected increment once every N running cycles. For a faster clock the corrected value is the nominal plus an adjustment, and for a slower clock it is the nominal minus the adjustment.

The count can roll over at a programmable period, which defaults to 2^31, or at its natural 31-bit width. Software reaches the block through a simple write port and a combinational read port. Through these ports it starts and stops the count, sets both increments and the correction cadence, captures the running value, and loads a new value to step the time. The live count and a one-cycle rollover pulse go to compare logic elsewhere on the chip.

Top module: `ns_time_counter`

## Requirements
- R1: After reset the count is 0 and the wrap pulse is low. Reads return 0 for control, increment, correction period and captured time, and 0x8000_0000 for the period register (address 4).
- R2: The count and the correction cadence change only while the run bit (control bit 0, address 0) is 1. With the run bit at 0 the count holds its value.
- R3: With a correction period of 0, every running cycle adds the nominal increment, taken from bits 6:0 of the increment register (address 1).
- R4: With a correction period N > 0 (address 2), every Nth running cycle adds the corrected increment (bits 14:8 of the increment register) in place of the nominal one. N = 1 corrects every cycle.
- R5: A write to the correction period register restarts the cadence. The first corrected step is the Nth running cycle after the write.
- R6: With period reset enabled (control bit 1), a sum at or above the period value becomes the sum minus the period. The wrap output is high for exactly the cycles in which the count shows such a rolled-over value.
- R7: With period reset disabled, the count wraps modulo 2^31 and the wrap output pulses on that rollover.
- R8: A control write with bit 2 set latches the count held before that clock edge into the captured-time register (read at address 3). Bit 2 reads back as 0.
- R9: A write to address 3 loads bits 30:0 into the count at that edge, with no increment added and no wrap pulse.
- R10: Each register reads back the value written. Addresses 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| time_o | output | 31 | Live nanosecond count |
| wrap_o | output | 1 | One-cycle rollover pulse |

## Verification
A corrected step can land in the same cycle as a period rollover. When it does, the rolled-over value has to subtract the period from a sum built on the corrected increment, not the nominal one. The bench provokes this case with a small period of 100 and a correction period of 3, and runs long enough for corrected steps and rollovers to coincide several times. It judges every cycle's count and wrap against an arithmetic model computed from the requirements. A capture write that arrives while the count is running is also judged: the captured value must equal the count before that edge, not the value after it.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_INC    = 3'd1;
  localparam logic [2:0] A_CPER   = 3'd2;
  localparam logic [2:0] A_TIME   = 3'd3;
  localparam logic [2:0] A_PERIOD = 3'd4;

  localparam int CTL_RUN  = 0;
  localparam int CTL_PRST = 1;
  localparam int CTL_CAP  = 2;

  localparam int COR_LSB = 8;
endpackage

// File: rtl/tc_regs.sv
module tc_regs
  import tc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 31,
  parameter int INC_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              run_o,
  output logic              prst_o,
  output logic [INC_W-1:0]  nom_o,
  output logic [INC_W-1:0]  cor_o,
  output logic [DATA_W-1:0] cper_o,
  output logic              cper_wr_o,
  output logic [CNT_W:0]    period_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o
);
  localparam int PER_W = CNT_W + 1;
  localparam logic [PER_W-1:0] PER_RST = {1'b1, {CNT_W{1'b0}}};

  logic              run_q, prst_q;
  logic [INC_W-1:0]  nom_q, cor_q;
  logic [DATA_W-1:0] cper_q;
  logic [PER_W-1:0]  period_q;
  logic [CNT_W-1:0]  cap_q;
  logic              ctl_wr;

  assign ctl_wr = wr_en && (wr_addr == A_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      prst_q   <= 1'b0;
      nom_q    <= '0;
      cor_q    <= '0;
      cper_q   <= '0;
      period_q <= PER_RST;
      cap_q    <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          run_q  <= wr_data[CTL_RUN];
          prst_q <= wr_data[CTL_PRST];
          if (wr_data[CTL_CAP]) cap_q <= cnt_i;
        end
        A_INC: begin
          nom_q <= wr_data[INC_W-1:0];
          cor_q <= wr_data[COR_LSB +: INC_W];
        end
        A_CPER:   cper_q   <= wr_data;
        A_PERIOD: period_q <= wr_data[PER_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_data[CTL_RUN]  = run_q;
        rd_data[CTL_PRST] = prst_q;
      end
      A_INC: begin
        rd_data[INC_W-1:0]        = nom_q;
        rd_data[COR_LSB +: INC_W] = cor_q;
      end
      A_CPER:   rd_data = cper_q;
      A_TIME:   rd_data[CNT_W-1:0] = cap_q;
      A_PERIOD: rd_data[PER_W-1:0] = period_q;
      default:  rd_data = '0;
    endcase
  end

  assign run_o      = run_q;
  assign prst_o     = prst_q;
  assign nom_o      = nom_q;
  assign cor_o      = cor_q;
  assign cper_o     = cper_q;
  assign period_o   = period_q;
  assign cper_wr_o  = wr_en && (wr_addr == A_CPER);
  assign load_o     = wr_en && (wr_addr == A_TIME);
  assign load_val_o = wr_data[CNT_W-1:0];

  // R8: capture latches the pre-edge count
  assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && wr_data[CTL_CAP]) |=> (cap_q == $past(cnt_i)));
endmodule

// File: rtl/tc_step_sel.sv
module tc_step_sel #(
  parameter int DATA_W = 32,
  parameter int INC_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv_i,
  input  logic              restart_i,
  input  logic [DATA_W-1:0] cper_i,
  input  logic [INC_W-1:0]  nom_i,
  input  logic [INC_W-1:0]  cor_i,
  output logic [INC_W-1:0]  step_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] cc_q;
  logic              corr_on, hit;

  assign corr_on = (cper_i != '0);
  assign hit     = corr_on && (cc_q == cper_i - ONE);
  assign step_o  = hit ? cor_i : nom_i;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cc_q <= '0;
    else if (restart_i)         cc_q <= '0;
    else if (adv_i) begin
      if (hit || !corr_on)      cc_q <= '0;
      else                      cc_q <= cc_q + ONE;
    end
  end

  // R4: cadence counter stays inside the programmed period
  assert_cadence_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cper_i != '0) |-> (cc_q < cper_i));
  // R5: a cadence write restarts the count
  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cc_q == '0));
endmodule

// File: rtl/tc_accum.sv
module tc_accum #(
  parameter int CNT_W = 31,
  parameter int INC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             prst_i,
  input  logic [CNT_W:0]   period_i,
  input  logic [INC_W-1:0] step_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, diff;
  logic [SUM_W-1:0] sum;
  logic             wrap_q, wrap_d, over;

  assign sum  = {1'b0, cnt_q} + SUM_W'(step_i);
  assign diff = sum[CNT_W-1:0] - period_i[CNT_W-1:0];
  assign over = prst_i ? (sum >= period_i) : sum[CNT_W];

  always_comb begin
    cnt_d  = cnt_q;
    wrap_d = 1'b0;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (run_i) begin
      wrap_d = over;
      cnt_d  = (prst_i && over) ? diff : sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      wrap_q <= wrap_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;

  // R2: idle counter holds
  assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !load_i) |=> $stable(cnt_q));
  // R9: load takes the written value
  assert_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i) && !wrap_q));
  // R3: without rollover the count never goes backwards
  assert_monotone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !load_i) |=> (wrap_q || cnt_q >= $past(cnt_q)));
  // R6: rolled-over value lands below the period
  assert_wrap_below_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && prst_i && !load_i && {1'b0, cnt_q} < period_i &&
     period_i > SUM_W'(2**INC_W))
    |=> (!wrap_q || {1'b0, cnt_q} < $past(period_i)));
endmodule

// File: rtl/ns_time_counter.sv
module ns_time_counter #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 31,
  parameter int INC_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [CNT_W-1:0]  time_o,
  output logic              wrap_o
);
  logic              run, prst, cper_wr, load;
  logic [INC_W-1:0]  nom, cor, step;
  logic [DATA_W-1:0] cper;
  logic [CNT_W:0]    period;
  logic [CNT_W-1:0]  load_val, cnt;

  tc_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .INC_W(INC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .cnt_i(cnt), .run_o(run), .prst_o(prst), .nom_o(nom), .cor_o(cor),
    .cper_o(cper), .cper_wr_o(cper_wr), .period_o(period),
    .load_o(load), .load_val_o(load_val));

  tc_step_sel #(.DATA_W(DATA_W), .INC_W(INC_W)) u_step (
    .clk(clk), .rst_n(rst_n), .adv_i(run), .restart_i(cper_wr),
    .cper_i(cper), .nom_i(nom), .cor_i(cor), .step_o(step));

  tc_accum #(.CNT_W(CNT_W), .INC_W(INC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .run_i(run), .prst_i(prst),
    .period_i(period), .step_i(step), .load_i(load),
    .load_val_i(load_val), .cnt_o(cnt), .wrap_o(wrap_o));

  assign time_o = cnt;
endmodule

// File: tb/tb_ns_time_counter.sv
module tb_ns_time_counter;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [30:0] time_o;
  logic        wrap_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  logic [30:0] m_cnt = '0, m_cap = '0;
  logic        m_run = 0, m_prst = 0, m_wrap = 0;
  logic [6:0]  m_nom = '0, m_cor = '0;
  logic [31:0] m_cper = '0, m_cc = '0, m_period = 32'h8000_0000;

  always #(CLK_PERIOD/2) clk = ~clk;

  ns_time_counter dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .time_o(time_o), .wrap_o(wrap_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model(input logic we, input logic [2:0] a, input logic [31:0] d);
    logic [30:0] n_cnt = m_cnt;
    logic [31:0] n_cc = m_cc;
    logic        n_wrap = 0;
    logic [31:0] sum;
    logic        hit;
    if (m_run) begin
      hit = (m_cper != 0) && (m_cc == m_cper - 1);
      sum = {1'b0, m_cnt} + {25'd0, (hit ? m_cor : m_nom)};
      n_cc = (hit || m_cper == 0) ? 32'd0 : m_cc + 1;
      if (m_prst) begin
        if (sum >= m_period) begin n_cnt = 31'(sum - m_period); n_wrap = 1; end
        else n_cnt = sum[30:0];
      end else begin
        n_cnt = sum[30:0]; n_wrap = sum[31];
      end
    end
    if (we) begin
      case (a)
        3'd0: begin m_run = d[0]; m_prst = d[1]; if (d[2]) m_cap = m_cnt; end
        3'd1: begin m_nom = d[6:0]; m_cor = d[14:8]; end
        3'd2: begin m_cper = d; n_cc = 0; end
        3'd3: begin n_cnt = d[30:0]; n_wrap = 0; end
        3'd4: m_period = d;
        default: ;
      endcase
    end
    m_cnt = n_cnt; m_cc = n_cc; m_wrap = n_wrap;
  endtask

  // one clock; inputs driven at negedge, outputs checked at the next negedge
  task automatic cyc(input string req, input logic we, input logic [2:0] a, input logic [31:0] d);
    wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    model(we, a, d);
    @(negedge clk);
    wr_en = 0;
    chk(req, {wrap_o, time_o}, {m_wrap, m_cnt});
  endtask

  task automatic idle(input string req, input int n);
    for (int i = 0; i < n; i++) cyc(req, 0, 3'd0, 32'd0);
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
    rd_addr = a; #1;
    chk(req, rd_data, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 time", {wrap_o, time_o}, 32'd0);
    rd("R1 ctrl", 3'd0, 32'd0);
    rd("R1 inc", 3'd1, 32'd0);
    rd("R1 cper", 3'd2, 32'd0);
    rd("R1 cap", 3'd3, 32'd0);
    rd("R1 period", 3'd4, 32'h8000_0000);

    // R2: increment set but not running
    cyc("R10 inc", 1, 3'd1, 32'h0000_0305);
    rd("R10 inc rb", 3'd1, 32'h0000_0305);
    rd("R10 unused addr", 3'd6, 32'd0);
    idle("R2 stopped", 5);
    chk("R2 still zero", {1'b0, time_o}, 32'd0);
    cyc("R2 start", 1, 3'd0, 32'd1);
    idle("R3 run", 4);

    // R3/R4 sweep: nominal, faster and slower correction, cadence 0..4
    foreach (m_nom[i]) begin end
    for (int ni = 0; ni < 3; ni++) begin
      for (int ci = 0; ci < 2; ci++) begin
        for (int cp = 0; cp < 5; cp++) begin
          logic [6:0] nom = (ni == 0) ? 7'd1 : (ni == 1) ? 7'd3 : 7'd8;
          logic [6:0] cor = (ci == 0) ? nom + 7'd2 : nom - 7'd1;
          string tag = (cp == 0) ? "R3 nominal" : "R4 corrected";
          cyc("R9 load zero", 1, 3'd3, 32'd0);
          cyc(tag, 1, 3'd1, {17'd0, cor, 1'b0, nom});
          cyc(tag, 1, 3'd2, cp);
          idle(tag, 12);
        end
      end
    end

    // R5 restart of cadence
    cyc("R5 cper", 1, 3'd2, 32'd4);
    idle("R5 part", 2);
    cyc("R5 rewrite", 1, 3'd2, 32'd4);
    idle("R5 after", 9);
    rd("R10 cper rb", 3'd2, 32'd4);

    // R9 mid-run load
    cyc("R9 load", 1, 3'd3, 32'd1000);
    chk("R9 value", {1'b0, time_o}, 32'd1000);
    idle("R9 continue", 3);

    // R6 small period with correction landing on rollovers
    cyc("R6 period", 1, 3'd4, 32'd100);
    rd("R10 period rb", 3'd4, 32'd100);
    cyc("R6 inc", 1, 3'd1, 32'h0000_0D07);
    cyc("R6 load", 1, 3'd3, 32'd0);
    cyc("R6 cper", 1, 3'd2, 32'd3);
    cyc("R6 ctrl", 1, 3'd0, 32'd3);
    idle("R6 wrap", 60);

    // R8 capture while running
    cyc("R8 capture", 1, 3'd0, 32'd7);
    rd("R8 cap value", 3'd3, {1'b0, m_cap});
    rd("R8 cap bit clear", 3'd0, 32'd3);

    // R7 natural rollover
    cyc("R7 ctrl", 1, 3'd0, 32'd1);
    cyc("R7 cper", 1, 3'd2, 32'd0);
    cyc("R7 load", 1, 3'd3, 32'h7FFF_FFF0);
    idle("R7 wrap", 5);

    // R2 stop holds
    cyc("R2 stop", 1, 3'd0, 32'd0);
    idle("R2 hold", 5);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule